// File: doc/BRIEF.md
# Parity-Guarded Write-Through Data Cache

This block is a direct-mapped data cache that sits between a load/store unit and a slower word-wide memory port. Every tag and every data word in the cache carries one even-parity bit, so a single flipped storage bit is noticed the next time that entry would have supplied a hit. Such a hit is demoted to a miss. The line is dropped and, for loads, fetched again from memory, so the processor never consumes corrupted data.

Stores always go through to memory, which keeps memory as the only authoritative copy and makes every cached line disposable. A store that hits also updates the cached word and its parity. A store that misses leaves the cache untouched. Test inputs can invert a stored parity bit in place, so the detection and recovery path can be exercised without real upsets. Each detected error raises a single-cycle pulse and advances a running error count.

Top module: `dcp_cache_top`

## Requirements
- R1: The byte address is split as byte offset [1:0], word-in-line [3:2], line index [7:4] (16 lines) and tag [31:8]; each line holds four 32-bit words. A load that hits raises cpu_ready and cpu_hit in the cycle its request is presented, with the cached word on cpu_rdata.
- R2: A load miss fetches the whole line as four single-word memory reads in ascending address order starting at the line base, with all byte enables set. The block then returns the memory word with cpu_ready high and cpu_hit low.
- R3: Whenever a tag or a data word is written (line refill or store hit), its stored parity bit is set to the XOR of all of its bits (even parity).
- R4: Parity is checked only when the line is valid and its stored tag equals the request tag, and only for the tag and the word being accessed. Lookups that miss for any other reason, and other words of the line, never report an error.
- R5: When the tag check or the accessed-word check fails, the line is invalidated and the access is handled as a miss. A load refills and returns the correct memory data with cpu_hit low. A store is still written to memory with cpu_hit low, and a later load of that line misses.
- R6: Each detected error gives a parity_error pulse lasting exactly one cycle, in the cycle after the failing lookup. In the same cycle parity_error_count rises by one.
- R7: Every store produces exactly one memory write with mem_we high, carrying the word-aligned request address, the store data and the byte enables. cpu_ready rises in the cycle of mem_ack, with cpu_hit high only if the store hit.
- R8: A store hit replaces exactly the enabled bytes of the cached word, and later load hits return the merged word.
- R9: A store miss does not allocate: a line already cached at that index keeps hitting afterwards.
- R10: A one-cycle pulse on inj_word_flip inverts the stored parity bit of word inj_word in line inj_idx. A pulse on inj_tag_flip inverts the tag parity bit of line inj_idx.
- R11: After reset all lines are invalid, and cpu_ready, mem_req, parity_error and parity_error_count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held stable until cpu_ready, dropped the cycle after |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete |
| cpu_hit | output | 1 | Access was served by a clean cache hit |
| mem_req | output | 1 | Memory transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | Transfer done; one pulse per transfer |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| inj_tag_flip | input | 1 | Invert the tag parity bit of line inj_idx |
| inj_word_flip | input | 1 | Invert the parity bit of word inj_word of line inj_idx |
| inj_idx | input | 4 | Line selected for injection |
| inj_word | input | 2 | Word selected for injection |
| parity_error | output | 1 | One-cycle pulse per detected parity error |
| parity_error_count | output | 16 | Number of detected parity errors |

## Verification
The load/store path is driven with a table of loads and stores spread over several tags that share one index. Cold misses, hits, stores that hit, stores that miss, partial byte enables and evictions are mixed, so that hit-versus-miss, merged data and non-allocation each give a different visible result. Injected parity flips are aimed at the tag, at the accessed word, at a different word of the same line, at a line holding another tag and at an invalid line. This separates errors that must be reported and recovered from flips that must stay silent. A final flip under a store shows that the write still reaches memory while the line is dropped.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } dcp_state_e;

endpackage

// File: rtl/dcp_tag_store.sv
module dcp_tag_store #(
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] line_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_par,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inv_en,
    input  logic             flip_en,
    input  logic [IDX_W-1:0] flip_idx
);

    typedef struct packed {
        logic [SETS-1:0]            valid;
        logic [SETS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0]            par;
    } tag_regs_t;

    tag_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inv_en) begin
            st_d.valid[line_idx] = 1'b0;
        end
        if (fill_en) begin
            st_d.valid[line_idx] = 1'b1;
            st_d.tag[line_idx]   = fill_tag;
            st_d.par[line_idx]   = ^fill_tag;
        end
        if (flip_en) begin
            st_d.par[flip_idx] = ~st_d.par[flip_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid[line_idx];
    assign rd_tag   = st_q.tag[line_idx];
    assign rd_par   = st_q.par[line_idx];

    AST_TAG_PARITY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flip_en) |=> ((^st_q.tag[$past(line_idx)]) == st_q.par[$past(line_idx)])); // R3

    AST_FILL_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> st_q.valid[$past(line_idx)]); // R2

    AST_INVALIDATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !fill_en) |=> !st_q.valid[$past(line_idx)]); // R5

endmodule

// File: rtl/dcp_data_store.sv
module dcp_data_store #(
    parameter int SETS       = 16,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WOFF_W = $clog2(LINE_WORDS),
    localparam int BE_W   = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [WOFF_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_par,
    input  logic              wr_en,
    input  logic [WOFF_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              flip_en,
    input  logic [IDX_W-1:0]  flip_idx,
    input  logic [WOFF_W-1:0] flip_word
);

    typedef struct packed {
        logic [SETS-1:0][LINE_WORDS-1:0][WORD_W-1:0] data;
        logic [SETS-1:0][LINE_WORDS-1:0]             par;
    } data_regs_t;

    data_regs_t st_d, st_q;

    logic [WORD_W-1:0] byte_mask;
    logic [WORD_W-1:0] merged;

    for (genvar b = 0; b < BE_W; b++) begin : g_mask
        assign byte_mask[b*8 +: 8] = {8{wr_be[b]}};
    end

    assign merged = (st_q.data[line_idx][wr_word] & ~byte_mask) | (wr_data & byte_mask);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.data[line_idx][wr_word] = merged;
            st_d.par[line_idx][wr_word]  = ^merged;
        end
        if (flip_en) begin
            st_d.par[flip_idx][flip_word] = ~st_d.par[flip_idx][flip_word];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data[line_idx][rd_word];
    assign rd_par  = st_q.par[line_idx][rd_word];

    AST_WORD_PARITY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flip_en) |=>
        ((^st_q.data[$past(line_idx)][$past(wr_word)]) == st_q.par[$past(line_idx)][$past(wr_word)])); // R3

    AST_FULL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_be)) |=> (st_q.data[$past(line_idx)][$past(wr_word)] == $past(wr_data))); // R8

endmodule

// File: rtl/dcp_ctrl.sv
module dcp_ctrl
    import dcp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 16,
    parameter int CNT_W      = 16,
    localparam int BE_W   = WORD_W / 8,
    localparam int BYTE_W = $clog2(BE_W),
    localparam int WOFF_W = $clog2(LINE_WORDS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  line_idx,
    output logic [WOFF_W-1:0] look_word,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_tag_par,
    input  logic [WORD_W-1:0] lk_data,
    input  logic              lk_data_par,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              fill_en,
    output logic              inv_en,
    output logic              dwr_en,
    output logic [WOFF_W-1:0] dwr_word,
    output logic [WORD_W-1:0] dwr_data,
    output logic [BE_W-1:0]   dwr_be,
    output logic              parity_error,
    output logic [CNT_W-1:0]  parity_error_count
);

    localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(LINE_WORDS - 1);

    typedef struct packed {
        dcp_state_e        state;
        logic [WOFF_W-1:0] cnt;
        logic              missed;
        logic              st_hit;
        logic              perr;
        logic [CNT_W-1:0]  errs;
    } ctl_regs_t;

    ctl_regs_t n_d, n_q;

    logic [TAG_W-1:0] a_tag;
    logic             tag_match;
    logic             tag_ok;
    logic             word_ok;
    logic             lk_hit;
    logic             lk_bad;
    logic             addr_unused;

    assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign line_idx    = cpu_addr[BYTE_W+WOFF_W +: IDX_W];
    assign look_word   = cpu_addr[BYTE_W +: WOFF_W];
    assign fill_tag    = a_tag;
    assign addr_unused = ^cpu_addr[BYTE_W-1:0];

    assign tag_match = lk_valid && (lk_tag == a_tag);
    assign tag_ok    = ((^lk_tag) == lk_tag_par);
    assign word_ok   = ((^lk_data) == lk_data_par);
    assign lk_hit    = tag_match && tag_ok && word_ok;
    assign lk_bad    = tag_match && !(tag_ok && word_ok);

    always_comb begin
        n_d       = n_q;
        n_d.perr  = 1'b0;
        cpu_rdata = lk_data;
        cpu_ready = 1'b0;
        cpu_hit   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = cpu_wdata;
        mem_be    = '1;
        fill_en   = 1'b0;
        inv_en    = 1'b0;
        dwr_en    = 1'b0;
        dwr_word  = look_word;
        dwr_data  = cpu_wdata;
        dwr_be    = cpu_be;

        unique case (n_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lk_bad) begin
                        n_d.perr = 1'b1;
                        n_d.errs = n_q.errs + 1'b1;
                        inv_en   = 1'b1;
                    end
                    if (!cpu_we) begin
                        if (lk_hit) begin
                            cpu_ready  = 1'b1;
                            cpu_hit    = !n_q.missed;
                            n_d.missed = 1'b0;
                        end else begin
                            inv_en     = 1'b1;
                            n_d.state  = ST_FILL;
                            n_d.cnt    = '0;
                            n_d.missed = 1'b1;
                        end
                    end else begin
                        dwr_en     = lk_hit;
                        n_d.st_hit = lk_hit;
                        n_d.state  = ST_WRITE;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {cpu_addr[ADDR_W-1:BYTE_W+WOFF_W], n_q.cnt, {BYTE_W{1'b0}}};
                if (mem_ack) begin
                    dwr_en   = 1'b1;
                    dwr_word = n_q.cnt;
                    dwr_data = mem_rdata;
                    dwr_be   = '1;
                    if (n_q.cnt == LAST_WORD) begin
                        fill_en   = 1'b1;
                        n_d.state = ST_IDLE;
                    end else begin
                        n_d.cnt = n_q.cnt + 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
                mem_be   = cpu_be;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    cpu_hit   = n_q.st_hit;
                    n_d.state = ST_IDLE;
                end
            end
            default: begin
                n_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '{state: ST_IDLE, default: '0};
        end else begin
            n_q <= n_d;
        end
    end

    assign parity_error       = n_q.perr;
    assign parity_error_count = n_q.errs;

    AST_ERROR_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        parity_error |-> (parity_error_count == CNT_W'($past(parity_error_count) + 1'b1))); // R6

    AST_ERROR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        parity_error |=> !parity_error); // R6

    AST_BAD_LOOKUP_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.state == ST_IDLE && cpu_req && lk_bad) |-> !cpu_ready); // R5

    AST_REFILL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.state == ST_FILL && mem_ack && n_q.cnt != LAST_WORD) |=>
        (mem_addr == $past(mem_addr) + ADDR_W'(BE_W))); // R2

endmodule

// File: rtl/dcp_cache_top.sv
module dcp_cache_top #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 16,
    parameter int CNT_W      = 16,
    localparam int BE_W   = WORD_W / 8,
    localparam int BYTE_W = $clog2(BE_W),
    localparam int WOFF_W = $clog2(LINE_WORDS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              inj_tag_flip,
    input  logic              inj_word_flip,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [WOFF_W-1:0] inj_word,
    output logic              parity_error,
    output logic [CNT_W-1:0]  parity_error_count
);

    logic [IDX_W-1:0]  line_idx;
    logic [WOFF_W-1:0] look_word;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_tag_par;
    logic [WORD_W-1:0] lk_data;
    logic              lk_data_par;
    logic [TAG_W-1:0]  fill_tag;
    logic              fill_en;
    logic              inv_en;
    logic              dwr_en;
    logic [WOFF_W-1:0] dwr_word;
    logic [WORD_W-1:0] dwr_data;
    logic [BE_W-1:0]   dwr_be;

    dcp_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
        .SETS(SETS), .CNT_W(CNT_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .line_idx(line_idx), .look_word(look_word),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_tag_par(lk_tag_par),
        .lk_data(lk_data), .lk_data_par(lk_data_par),
        .fill_tag(fill_tag), .fill_en(fill_en), .inv_en(inv_en),
        .dwr_en(dwr_en), .dwr_word(dwr_word), .dwr_data(dwr_data), .dwr_be(dwr_be),
        .parity_error(parity_error), .parity_error_count(parity_error_count)
    );

    dcp_tag_store #(
        .SETS(SETS), .TAG_W(TAG_W)
    ) i_tags (
        .clk(clk), .rst_n(rst_n),
        .line_idx(line_idx),
        .rd_valid(lk_valid), .rd_tag(lk_tag), .rd_par(lk_tag_par),
        .fill_en(fill_en), .fill_tag(fill_tag),
        .inv_en(inv_en),
        .flip_en(inj_tag_flip), .flip_idx(inj_idx)
    );

    dcp_data_store #(
        .SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
    ) i_data (
        .clk(clk), .rst_n(rst_n),
        .line_idx(line_idx),
        .rd_word(look_word), .rd_data(lk_data), .rd_par(lk_data_par),
        .wr_en(dwr_en), .wr_word(dwr_word), .wr_data(dwr_data), .wr_be(dwr_be),
        .flip_en(inj_word_flip), .flip_idx(inj_idx), .flip_word(inj_word)
    );

endmodule

// File: tb/test_dcp_cache_top.sv
module test_dcp_cache_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        cpu_hit;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        inj_tag_flip = 1'b0;
    logic        inj_word_flip = 1'b0;
    logic [3:0]  inj_idx = '0;
    logic [1:0]  inj_word = '0;
    logic        parity_error;
    logic [15:0] parity_error_count;

    always #2 clk = ~clk;

    dcp_cache_top i_dcp_cache_top (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .inj_tag_flip(inj_tag_flip), .inj_word_flip(inj_word_flip),
        .inj_idx(inj_idx), .inj_word(inj_word),
        .parity_error(parity_error), .parity_error_count(parity_error_count)
    );

    // Memory model: 4 KB of words, one ack per transfer, one cycle after the request.
    logic [31:0] gmem [1024];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 1024; i++) gmem[i] <= (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= gmem[mem_addr[11:2]];
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) gmem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                end
            end
        end
    end

    // Transfer monitors
    int          fill_n = 0;
    logic [31:0] fill_log [8];
    int          wr_n = 0;
    logic [31:0] last_w_addr, last_w_data;
    logic [3:0]  last_w_be;
    int          pulse_n = 0;

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack && !mem_we) begin
            if (fill_n < 8) fill_log[fill_n] = mem_addr;
            fill_n = fill_n + 1;
        end
        if (rst_n && mem_req && mem_ack && mem_we) begin
            wr_n        = wr_n + 1;
            last_w_addr = mem_addr;
            last_w_data = mem_wdata;
            last_w_be   = mem_be;
        end
        if (rst_n && parity_error) pulse_n = pulse_n + 1;
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output logic hit);
        int waited;
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = wd;
        cpu_be    = be;
        waited    = 0;
        #1;
        while (!cpu_ready && waited < 200) begin
            @(negedge clk);
            #1;
            waited++;
        end
        rd  = cpu_rdata;
        hit = cpu_hit;
        if (!cpu_ready) chk(1'b0, "handshake cpu_ready", 32'(waited), 32'd0);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic inject(input bit tag, input logic [3:0] idx, input logic [1:0] word);
        @(negedge clk);
        inj_idx       = idx;
        inj_word      = word;
        inj_tag_flip  = tag;
        inj_word_flip = !tag;
        @(negedge clk);
        inj_tag_flip  = 1'b0;
        inj_word_flip = 1'b0;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd, input logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = wd[b*8 +: 8];
        return r;
    endfunction

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        hit;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h000, 32'h0,         4'hF, 1'b0},  // cold miss       R11 R2
        '{1'b0, 32'h004, 32'h0,         4'hF, 1'b1},  // hit             R1
        '{1'b0, 32'h00C, 32'h0,         4'hF, 1'b1},  // hit             R1
        '{1'b1, 32'h008, 32'hDEAD_BEEF, 4'hF, 1'b1},  // store hit       R7
        '{1'b0, 32'h008, 32'h0,         4'hF, 1'b1},  // merged word     R8
        '{1'b1, 32'h014, 32'h0000_1234, 4'h3, 1'b0},  // store miss      R7
        '{1'b0, 32'h014, 32'h0,         4'hF, 1'b0},  // no allocation   R9
        '{1'b0, 32'h100, 32'h0,         4'hF, 1'b0},  // evict index 0   R2
        '{1'b0, 32'h000, 32'h0,         4'hF, 1'b0},  // refill tag 0    R2
        '{1'b1, 32'h200, 32'h7777_7777, 4'hF, 1'b0},  // store miss      R9
        '{1'b0, 32'h004, 32'h0,         4'hF, 1'b1},  // still cached    R9
        '{1'b1, 32'h006, 32'hABCD_0000, 4'hC, 1'b1},  // partial store   R8
        '{1'b0, 32'h004, 32'h0,         4'hF, 1'b1}   // merged halves   R8
    };

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        n_fail++;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        hit;
        logic [31:0] exp_w;
        int          wr_before;
        int          fills_before;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: idle outputs after reset
        chk(cpu_ready == 1'b0, "R11 cpu_ready after reset", 32'(cpu_ready), 32'd0);
        chk(mem_req == 1'b0, "R11 mem_req after reset", 32'(mem_req), 32'd0);
        chk(parity_error == 1'b0, "R11 parity_error after reset", 32'(parity_error), 32'd0);
        chk(parity_error_count == 16'd0, "R11 error count after reset", 32'(parity_error_count), 32'd0);

        for (int i = 0; i < NV; i++) begin
            exp_w     = gmem[VECS[i].addr[11:2]];
            wr_before = wr_n;
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, rd, hit);
            if (!VECS[i].we) begin
                chk(rd == exp_w, "R1 R2 R8 load data", rd, exp_w);
                chk(hit == VECS[i].hit, "R1 R2 R9 load hit flag", 32'(hit), 32'(VECS[i].hit));
            end else begin
                exp_w = merge(exp_w, VECS[i].wdata, VECS[i].be);
                chk(wr_n == wr_before + 1, "R7 one memory write per store", 32'(wr_n - wr_before), 32'd1);
                chk(last_w_addr == {VECS[i].addr[31:2], 2'b00}, "R7 write address", last_w_addr, {VECS[i].addr[31:2], 2'b00});
                chk(last_w_data == VECS[i].wdata && last_w_be == VECS[i].be, "R7 write data and enables",
                    last_w_data, VECS[i].wdata);
                chk(gmem[VECS[i].addr[11:2]] == exp_w, "R7 memory updated", gmem[VECS[i].addr[11:2]], exp_w);
                chk(hit == VECS[i].hit, "R7 store hit flag", 32'(hit), 32'(VECS[i].hit));
            end
            if (i == 0) begin
                // R2: first refill, ascending from line base
                chk(fill_n == 4, "R2 refill read count", 32'(fill_n), 32'd4);
                for (int k = 0; k < 4; k++)
                    chk(fill_log[k] == 32'(k * 4), "R2 refill order", fill_log[k], 32'(k * 4));
            end
        end
        chk(parity_error_count == 16'd0, "R4 no error without injection", 32'(parity_error_count), 32'd0);

        // R10 R5: flip parity of accessed word
        inject(1'b0, 4'd0, 2'd1);
        fills_before = fill_n;
        access(1'b0, 32'h004, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b0, "R5 R10 word parity error is a miss", 32'(hit), 32'd0);
        chk(rd == gmem[1], "R5 recovered data", rd, gmem[1]);
        chk(fill_n == fills_before + 4, "R5 line refilled", 32'(fill_n - fills_before), 32'd4);
        chk(parity_error_count == 16'd1, "R6 count after first error", 32'(parity_error_count), 32'd1);
        chk(pulse_n == 1, "R6 one pulse per error", 32'(pulse_n), 32'd1);
        access(1'b0, 32'h004, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b1, "R5 hit after recovery", 32'(hit), 32'd1);

        // R10 R5: flip tag parity
        inject(1'b1, 4'd0, 2'd0);
        access(1'b0, 32'h00C, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b0, "R5 R10 tag parity error is a miss", 32'(hit), 32'd0);
        chk(rd == gmem[3], "R5 data after tag error", rd, gmem[3]);
        chk(parity_error_count == 16'd2, "R6 count after tag error", 32'(parity_error_count), 32'd2);

        // R4: flip on another word, then on a line holding another tag
        inject(1'b0, 4'd0, 2'd2);
        access(1'b0, 32'h004, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b1, "R4 other word not checked", 32'(hit), 32'd1);
        access(1'b0, 32'h100, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b0 && rd == gmem[64], "R4 tag mismatch miss", rd, gmem[64]);
        chk(parity_error_count == 16'd2, "R4 no error on tag mismatch", 32'(parity_error_count), 32'd2);
        access(1'b0, 32'h008, 32'h0, 4'hF, rd, hit);
        chk(rd == gmem[2], "R3 refill restores data", rd, gmem[2]);

        // R4: flip on an invalid line
        inject(1'b0, 4'd5, 2'd0);
        access(1'b0, 32'h050, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b0 && parity_error_count == 16'd2, "R4 no error on invalid line",
            32'(parity_error_count), 32'd2);
        access(1'b0, 32'h050, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b1, "R3 fresh parity after refill", 32'(hit), 32'd1);

        // R5: store onto a word with a flipped parity bit
        inject(1'b0, 4'd0, 2'd3);
        wr_before = wr_n;
        access(1'b1, 32'h00C, 32'h0BAD_F00D, 4'hF, rd, hit);
        chk(hit == 1'b0, "R5 store with parity error not a hit", 32'(hit), 32'd0);
        chk(wr_n == wr_before + 1 && gmem[3] == 32'h0BAD_F00D, "R5 R7 store still written",
            gmem[3], 32'h0BAD_F00D);
        chk(parity_error_count == 16'd3, "R6 count after store error", 32'(parity_error_count), 32'd3);
        access(1'b0, 32'h008, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b0 && rd == gmem[2], "R5 line dropped after store error", 32'(hit), 32'd0);
        access(1'b0, 32'h00C, 32'h0, 4'hF, rd, hit);
        chk(hit == 1'b1 && rd == 32'h0BAD_F00D, "R5 stored word reloaded", rd, 32'h0BAD_F00D);
        chk(pulse_n == 3, "R6 pulses equal errors", 32'(pulse_n), 32'd3);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule